// File: doc/BRIEF.md
# Endian-selectable bus-matching width converter

This block adapts a 36-bit word stream to a 9-bit or 18-bit piece stream, or the other way round, next to a FIFO. A build-time parameter picks the direction. Splitting takes one long word and hands out its pieces one per output transfer. Gathering collects pieces and presents one long word once the last piece has arrived. Both sides use a valid/ready handshake. A transfer happens on a rising clock edge when valid and ready are both high.

Two pins set the piece width and the piece order. The block samples them only while the synchronous master reset `rst_n` is low, and holds the sampled values until the next reset. Narrow pieces always sit right-justified on the 36-bit data ports.

Top module: `bus_width_conv`

## Requirements
- R1: `cfg_little` and `cfg_width` are sampled on every clock edge while `rst_n` is low and are ignored while `rst_n` is high. Changing them during operation does not alter piece size or order.
- R2: Width code 2'b01 selects 18-bit pieces and 2'b10 selects 9-bit pieces. Codes 2'b00 and 2'b11 select 36-bit pass-through. The piece width w defines lanes as consecutive w-bit slices counted from bit 0. A narrow piece uses data bits [w-1:0]. Split pieces carry zero above bit w-1, and bits of a narrow input above w-1 are ignored.
- R3: When splitting with `cfg_little` low at reset (big-endian), the most significant lane of a long word is output first, then each next lower lane.
- R4: When splitting with `cfg_little` high at reset (little-endian), lane 0 is output first, then each next higher lane.
- R5: When gathering in big-endian, the first accepted piece becomes the most significant lane of the long word and the last becomes lane 0.
- R6: When gathering in little-endian, the first accepted piece becomes lane 0 and the last becomes the most significant lane.
- R7: When splitting, `in_ready` is high exactly when no long word is held. An accepted word drops `in_ready` until the cycle after its final piece is taken.
- R8: When gathering, `out_valid` rises only after the final piece of a word is accepted. `in_ready` stays low while the long word waits at the output.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values on the next cycle.
- R10: While `rst_n` is low and in the first cycle after it, `out_valid` is low. A partly gathered or partly split word is discarded by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous master reset, active low; configuration is sampled while low |
| cfg_little | input | 1 | Order select: low big-endian, high little-endian |
| cfg_width | input | 2 | Piece width code |
| in_valid | input | 1 | Input word or piece offered |
| in_ready | output | 1 | Input accepted when high together with in_valid |
| in_data | input | 36 | Input word, or piece right-justified |
| out_valid | output | 1 | Output word or piece offered |
| out_ready | input | 1 | Downstream takes output when high together with out_valid |
| out_data | output | 36 | Output word, or piece right-justified |

## Verification
The case hardest to reach is a reset that arrives with a long word half gathered. In that case the leftover lane index or lane contents could corrupt the next word. The bench hands the gathering instance a single 9-bit piece and then pulses reset. Every later word is then checked against the reference. In a separate phase the configuration pins change on every cycle of normal operation, so any leak of the live pin values into the order or width shows up as a data mismatch.

// File: rtl/bus_width_conv.sv
module bus_width_conv #(
  parameter int LANE_W = 9,
  parameter bit NARROW_TO_WIDE = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_little,
  input  logic [1:0]          cfg_width,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [4*LANE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [4*LANE_W-1:0] out_data
);
  localparam int WIDE_W = 4 * LANE_W;

  logic              le_q;
  logic [1:0]        wm_q;
  logic [1:0]        idx_q;
  logic              busy_q;
  logic [WIDE_W-1:0] word_q;
  logic [1:0]        last_idx, pos;
  logic [7:0]        pw, sh;
  logic [WIDE_W-1:0] mask;

  always_ff @(posedge clk)
    if (!rst_n) begin
      le_q <= cfg_little;
      wm_q <= cfg_width;
    end

  assign pw       = (wm_q == 2'b01) ? 8'(2*LANE_W) : (wm_q == 2'b10) ? 8'(LANE_W) : 8'(WIDE_W);
  assign last_idx = (wm_q == 2'b01) ? 2'd1 : (wm_q == 2'b10) ? 2'd3 : 2'd0;
  assign pos      = le_q ? idx_q : last_idx - idx_q;
  assign sh       = {6'd0, pos} * pw;
  assign mask     = {WIDE_W{1'b1}} >> (8'(WIDE_W) - pw);

  assign in_ready  = !busy_q;
  assign out_valid = busy_q;

  generate
    if (!NARROW_TO_WIDE) begin : g_split
      assign out_data = (word_q >> sh) & mask;

      always_ff @(posedge clk)
        if (!rst_n) begin
          busy_q <= 1'b0;
          idx_q  <= 2'd0;
        end else if (in_valid && in_ready) begin
          word_q <= in_data;
          busy_q <= 1'b1;
          idx_q  <= 2'd0;
        end else if (out_valid && out_ready) begin
          if (idx_q == last_idx) busy_q <= 1'b0;
          else idx_q <= idx_q + 2'd1;
        end

      // R7
      split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && !in_ready);
    end else begin : g_gather
      assign out_data = word_q;

      always_ff @(posedge clk)
        if (!rst_n) begin
          busy_q <= 1'b0;
          idx_q  <= 2'd0;
        end else if (in_valid && in_ready) begin
          word_q <= (word_q & ~(mask << sh)) | ((in_data & mask) << sh);
          if (idx_q == last_idx) begin
            busy_q <= 1'b1;
            idx_q  <= 2'd0;
          end else idx_q <= idx_q + 2'd1;
        end else if (out_valid && out_ready) begin
          busy_q <= 1'b0;
        end

      // R8
      gather_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));
    end
  endgenerate

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R1
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(le_q) && $stable(wm_q));

  // R10
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

// File: tb/sim_bus_width_conv.sv
module sim_bus_width_conv;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, cfg_le = 1'b0;
  logic [1:0] cfg_wm = 2'b00;
  logic a_iv = 0, a_or = 0, b_iv = 0, b_or = 0;
  logic [35:0] a_id = 0, b_id = 0;
  logic a_ir, a_ov, b_ir, b_ov;
  logic [35:0] a_od, b_od;

  bus_width_conv #(.LANE_W(9), .NARROW_TO_WIDE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_little(cfg_le), .cfg_width(cfg_wm),
    .in_valid(a_iv), .in_ready(a_ir), .in_data(a_id),
    .out_valid(a_ov), .out_ready(a_or), .out_data(a_od));

  bus_width_conv #(.LANE_W(9), .NARROW_TO_WIDE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_little(cfg_le), .cfg_width(cfg_wm),
    .in_valid(b_iv), .in_ready(b_ir), .in_data(b_id),
    .out_valid(b_ov), .out_ready(b_or), .out_data(b_od));

  int checks = 0, errors = 0;
  bit m_le;
  int m_w = 36, m_n = 1;
  string extra = "";
  logic [35:0] qa[$], qb[$], part[$];
  bit hold_a, hold_b;
  logic [35:0] prev_a, prev_b;

  function automatic logic [35:0] msk();
    return 36'hF_FFFF_FFFF >> (36 - m_w);
  endfunction

  task automatic chk(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s%s actual=%h expected=%h", req, extra, act, exp);
    end
  endtask

  task automatic do_reset(bit le, logic [1:0] wm);
    @(negedge clk);
    rst_n = 0; cfg_le = le; cfg_wm = wm; a_iv = 0; b_iv = 0;
    repeat (3) @(negedge clk);
    chk(!a_ov && !b_ov, "R10", {34'd0, a_ov, b_ov}, 36'd0);
    rst_n = 1;
    m_le = le;
    m_w = (wm == 2'b01) ? 18 : (wm == 2'b10) ? 9 : 36;
    m_n = 36 / m_w;
    qa.delete(); qb.delete(); part.delete();
    hold_a = 0; hold_b = 0;
    extra = "";
  endtask

  task automatic run(int cycles, bit wiggle);
    repeat (cycles) begin
      @(negedge clk);
      if (wiggle) begin
        cfg_le = 1'($urandom);
        cfg_wm = 2'($urandom);
      end
      a_iv = ($urandom % 3) != 0;
      a_id = 36'({$urandom, $urandom});
      a_or = ($urandom % 4) != 0;
      b_iv = ($urandom % 3) != 0;
      b_id = 36'({$urandom, $urandom});
      b_or = ($urandom % 4) != 0;
      #1;
      // splitting side
      chk(a_ir == (qa.size() == 0), "R7", 36'(a_ir), 36'(qa.size() == 0));
      chk(a_ov == (qa.size() != 0), "R7", 36'(a_ov), 36'(qa.size() != 0));
      if (hold_a) chk(a_ov && a_od == prev_a, "R9", a_od, prev_a);
      if (a_ov && qa.size() > 0) begin
        chk(a_od == qa[0], m_n == 1 ? "R2" : (m_le ? "R4" : "R3"), a_od, qa[0]);
        chk((a_od & ~msk()) == 0, "R2", a_od & ~msk(), 36'd0);
      end
      if (a_ov && a_or && qa.size() > 0) void'(qa.pop_front());
      if (a_iv && a_ir)
        for (int k = 0; k < m_n; k++) begin
          int p = m_le ? k : m_n - 1 - k;
          qa.push_back((a_id >> (p * m_w)) & msk());
        end
      hold_a = a_ov && !a_or; prev_a = a_od;
      // gathering side
      chk(b_ir == (qb.size() == 0), "R8", 36'(b_ir), 36'(qb.size() == 0));
      chk(b_ov == (qb.size() != 0), "R8", 36'(b_ov), 36'(qb.size() != 0));
      if (hold_b) chk(b_ov && b_od == prev_b, "R9", b_od, prev_b);
      if (b_ov && qb.size() > 0)
        chk(b_od == qb[0], m_n == 1 ? "R2" : (m_le ? "R6" : "R5"), b_od, qb[0]);
      if (b_ov && b_or && qb.size() > 0) void'(qb.pop_front());
      if (b_iv && b_ir) begin
        part.push_back(b_id & msk());
        if (part.size() == m_n) begin
          logic [35:0] w = 0;
          for (int k = 0; k < m_n; k++) begin
            int p = m_le ? k : m_n - 1 - k;
            w |= part[k] << (p * m_w);
          end
          qb.push_back(w);
          part.delete();
        end
      end
      hold_b = b_ov && !b_or; prev_b = b_od;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int le = 0; le < 2; le++)
      for (int wm = 0; wm < 3; wm++) begin
        do_reset(1'(le), 2'(wm));
        run(300, 0);
      end
    // R2: reserved code behaves as pass-through
    do_reset(1'b1, 2'b11);
    run(200, 0);
    // R1: pins move every cycle after reset
    do_reset(1'b0, 2'b10);
    extra = " (R1 pins moving)";
    run(300, 1);
    do_reset(1'b1, 2'b01);
    extra = " (R1 pins moving)";
    run(300, 1);
    // R10: reset with one piece gathered
    do_reset(1'b1, 2'b10);
    @(negedge clk);
    b_iv = 1; b_id = 36'h0_0000_01A5; a_iv = 0;
    @(negedge clk);
    b_iv = 0;
    do_reset(1'b1, 2'b10);
    extra = " (R10 after mid-word reset)";
    run(300, 0);
    finish_run();
  end
endmodule